// File: doc/BRIEF.md
# Indirect Register-Access Bridge

This block lets a local processor reach registers that live on a separate peripheral bus. The processor sees four word registers: a control word, a target address, a data word and a timeout limit. It first writes the target address, the write data if there is any, and the timeout limit. A single control write then launches one 32-bit read or write on the external side. The bridge raises a request toward the external bus and holds it until the external side acknowledges or the timeout limit runs out. It then reports the outcome in a two-bit status field of the control word.

On the external side the bridge is a simple master: a level request with fixed address, direction, write data and byte strobes, ended by a one-cycle acknowledge. On a read, the acknowledged data lands in the data register, where the processor fetches it. Targets outside a parameterised address window are refused at once, without touching the external bus. Host register accesses select a word through a two-bit word index, so index 0..3 corresponds to byte offsets 0x0, 0x4, 0x8 and 0xC. Host reads are combinational from the current register state. The active-low reset is applied asynchronously and released through a two-stage synchroniser.

Top module: `ixb_bridge`

## Requirements
- R1: After reset the control word reads 0 (status idle), the address and data registers read 0, the timeout register reads 0x00000FFF, and x_req is low.
- R2: Word index 0 is the control word, 1 the address, 2 the data and 3 the timeout (byte offsets 0x0, 0x4, 0x8, 0xC). A host write to index 1, 2 or 3 while not busy is read back unchanged.
- R3: A transfer is accepted only on a control write with bit 31 (go) set and exactly one of bit 0 (read) and bit 1 (write) set. A control write with both direction bits, with neither, or with go clear starts nothing and leaves the status and the mask unchanged.
- R4: The control word reads status in bits 13:12, with 0 meaning idle, 1 meaning busy and 2 meaning error. It reads the latched byte mask in bits 7:4 and reads 0 in every other bit, including go and the direction bits. Status is busy from the cycle after an accepted in-range launch until the transfer ends.
- R5: From the cycle after an accepted in-range launch, x_req is high and x_addr, x_wdata and x_we hold the address register, the data register and the direction (1 means write). On a write, x_strb carries the mask from control bits 7:4 captured at launch. On a read, x_strb is 0. None of these outputs change while x_req stays high.
- R6: An accepted launch whose address lies outside [ADDR_BASE, ADDR_LIMIT] never raises x_req, and the status reads 2 in the next cycle.
- R7: When x_ack is sampled high while x_req is high, x_req drops and the status returns to 0 on the next cycle. On a read, the data register then holds x_rdata. On a write, the data register keeps its value.
- R8: If no acknowledge arrives, x_req stays high for exactly T cycles, where T is the timeout register (0 acts as 1). x_req then drops and the status reads 2, with the data register unchanged. An acknowledge in the T-th cycle still completes the transfer normally.
- R9: While busy, host writes to any register, including a new launch, are ignored.
- R10: Error status stays until the next accepted launch, which moves the status to busy (or back to error when out of range).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host access strobe |
| h_wr | input | 1 | Host access is a write |
| h_idx | input | 2 | Host word index (0 control, 1 address, 2 data, 3 timeout) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for the selected word |
| x_req | output | 1 | External request, held until acknowledge or timeout |
| x_we | output | 1 | External direction, 1 means write |
| x_addr | output | AW | External address |
| x_wdata | output | 32 | External write data |
| x_strb | output | 4 | External byte strobes (0 on reads) |
| x_ack | input | 1 | External acknowledge |
| x_rdata | input | 32 | External read data, valid with x_ack |

## Verification
A host write or launch takes effect at the clock edge that samples it. Host reads return state combinationally, so the bench samples a read a quarter period after driving it and sees the state left by the previous edge. The bench checks x_req, x_strb and status at the first falling edge after the launch edge. An acknowledge driven before edge k shows as idle status and new read data at the falling edge after edge k. With timeout T and no acknowledge, the bench checks that x_req is still high at T falling edges after launch and low at the next one, with error status. All stimulus is applied on falling edges, and expected read values are queued by the driver and compared by a monitor.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ERR  = 2'd2
  } ixb_st_e;

  typedef enum logic [1:0] {
    REG_CTL = 2'd0,
    REG_ADR = 2'd1,
    REG_DAT = 2'd2,
    REG_TMO = 2'd3
  } ixb_reg_e;

  localparam int CTL_RD_BIT   = 0;
  localparam int CTL_WR_BIT   = 1;
  localparam int CTL_MASK_LSB = 4;
  localparam int CTL_ST_LSB   = 12;
  localparam int CTL_GO_BIT   = 31;
endpackage

// File: rtl/ixb_rst_sync.sv
module ixb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/ixb_seq.sv
module ixb_seq
  import ixb_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            TW         = 16,
  parameter logic [AW-1:0] ADDR_BASE  = '0,
  parameter logic [AW-1:0] ADDR_LIMIT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          go_bit,
  input  logic          rd_bit,
  input  logic          wr_bit,
  input  logic [3:0]    mask_in,
  input  logic [AW-1:0] cur_addr,
  input  logic [TW-1:0] tmo,
  input  logic          x_ack,
  output ixb_st_e       st,
  output logic          rd_done,
  output logic [3:0]    mask,
  output logic          x_req,
  output logic          x_we,
  output logic [3:0]    x_strb
);
  localparam int CW = TW + 1;

  ixb_st_e       st_q, st_d;
  logic          req_q, req_d;
  logic          we_q, we_d;
  logic [3:0]    mask_q, mask_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          go_ok, in_rng, upd, limit_hit;

  assign go_ok     = ctl_we && go_bit && (rd_bit ^ wr_bit) && (st_q != ST_BUSY);
  assign in_rng    = (cur_addr >= ADDR_BASE) && (cur_addr <= ADDR_LIMIT);
  assign limit_hit = (CW'(cnt_q) + CW'(1)) >= CW'(tmo);
  assign upd       = go_ok || (st_q == ST_BUSY);

  always_comb begin
    st_d   = st_q;
    req_d  = req_q;
    we_d   = we_q;
    mask_d = mask_q;
    cnt_d  = cnt_q;
    if (go_ok) begin
      mask_d = mask_in;
      we_d   = wr_bit;
      cnt_d  = '0;
      if (in_rng) begin
        st_d  = ST_BUSY;
        req_d = 1'b1;
      end else begin
        st_d  = ST_ERR;
        req_d = 1'b0;
      end
    end else if (st_q == ST_BUSY) begin
      if (x_ack) begin
        st_d  = ST_IDLE;
        req_d = 1'b0;
      end else if (limit_hit) begin
        st_d  = ST_ERR;
        req_d = 1'b0;
      end else begin
        cnt_d = cnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      mask_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      st_q   <= st_d;
      req_q  <= req_d;
      we_q   <= we_d;
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end

  assign st      = st_q;
  assign mask    = mask_q;
  assign x_req   = req_q;
  assign x_we    = we_q;
  assign x_strb  = we_q ? mask_q : 4'h0;
  assign rd_done = (st_q == ST_BUSY) && x_ack && !we_q;
endmodule

// File: rtl/ixb_regs.sv
module ixb_regs
  import ixb_pkg::*;
#(
  parameter int            AW      = 32,
  parameter int            TW      = 16,
  parameter logic [TW-1:0] TMO_RST = TW'(12'hFFF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  ixb_reg_e      idx,
  input  logic [31:0]   wdata,
  input  logic          rd_done,
  input  logic [31:0]   x_rdata,
  input  ixb_st_e       st,
  input  logic [3:0]    mask,
  output logic [31:0]   rdata,
  output logic [AW-1:0] addr_q,
  output logic [31:0]   data_q,
  output logic [TW-1:0] tmo_q
);
  logic          adr_en, dat_en, tmo_en;
  logic [31:0]   dat_d;
  logic [31:0]   ctl_word;

  assign adr_en = wr_en && (idx == REG_ADR);
  assign tmo_en = wr_en && (idx == REG_TMO);
  assign dat_en = (wr_en && (idx == REG_DAT)) || rd_done;
  assign dat_d  = rd_done ? x_rdata : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      tmo_q  <= TMO_RST;
    end else begin
      if (adr_en) addr_q <= wdata[AW-1:0];
      if (dat_en) data_q <= dat_d;
      if (tmo_en) tmo_q  <= wdata[TW-1:0];
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_ST_LSB +: 2]   = st;
    ctl_word[CTL_MASK_LSB +: 4] = mask;
  end

  always_comb begin
    unique case (idx)
      REG_CTL: rdata = ctl_word;
      REG_ADR: rdata = 32'(addr_q);
      REG_DAT: rdata = data_q;
      default: rdata = 32'(tmo_q);
    endcase
  end
endmodule

// File: rtl/ixb_bridge.sv
module ixb_bridge
  import ixb_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            TW         = 16,
  parameter logic [TW-1:0] TMO_RST    = TW'(12'hFFF),
  parameter logic [AW-1:0] ADDR_BASE  = AW'(32'h0000_1000),
  parameter logic [AW-1:0] ADDR_LIMIT = AW'(32'h0000_FFFF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_sel,
  input  logic          h_wr,
  input  logic [1:0]    h_idx,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  output logic          x_req,
  output logic          x_we,
  output logic [AW-1:0] x_addr,
  output logic [31:0]   x_wdata,
  output logic [3:0]    x_strb,
  input  logic          x_ack,
  input  logic [31:0]   x_rdata
);
  logic          rst_s;
  ixb_st_e       st;
  ixb_reg_e      idx;
  logic          wr_any, ctl_we, reg_we, rd_done;
  logic [3:0]    mask;
  logic [AW-1:0] addr_q;
  logic [31:0]   data_q;
  logic [TW-1:0] tmo_q;

  assign idx    = ixb_reg_e'(h_idx);
  assign wr_any = h_sel && h_wr;
  assign ctl_we = wr_any && (idx == REG_CTL);
  assign reg_we = wr_any && (st != ST_BUSY);

  ixb_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_s)
  );

  ixb_seq #(
    .AW(AW), .TW(TW), .ADDR_BASE(ADDR_BASE), .ADDR_LIMIT(ADDR_LIMIT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_s),
    .ctl_we   (ctl_we),
    .go_bit   (h_wdata[CTL_GO_BIT]),
    .rd_bit   (h_wdata[CTL_RD_BIT]),
    .wr_bit   (h_wdata[CTL_WR_BIT]),
    .mask_in  (h_wdata[CTL_MASK_LSB +: 4]),
    .cur_addr (addr_q),
    .tmo      (tmo_q),
    .x_ack    (x_ack),
    .st       (st),
    .rd_done  (rd_done),
    .mask     (mask),
    .x_req    (x_req),
    .x_we     (x_we),
    .x_strb   (x_strb)
  );

  ixb_regs #(.AW(AW), .TW(TW), .TMO_RST(TMO_RST)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (reg_we),
    .idx     (idx),
    .wdata   (h_wdata),
    .rd_done (rd_done),
    .x_rdata (x_rdata),
    .st      (st),
    .mask    (mask),
    .rdata   (h_rdata),
    .addr_q  (addr_q),
    .data_q  (data_q),
    .tmo_q   (tmo_q)
  );

  assign x_addr  = addr_q;
  assign x_wdata = data_q;
endmodule

// File: rtl/ixb_bridge_chk.sv
module ixb_bridge_chk
  import ixb_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            TW         = 16,
  parameter logic [AW-1:0] ADDR_BASE  = '0,
  parameter logic [AW-1:0] ADDR_LIMIT = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic          go_bit,
  input logic          rd_bit,
  input logic          wr_bit,
  input logic          x_req,
  input logic          x_we,
  input logic [AW-1:0] x_addr,
  input logic [31:0]   x_wdata,
  input logic [3:0]    x_strb,
  input logic          x_ack,
  input ixb_st_e       st,
  input logic [TW-1:0] tmo_q
);
  logic          launch, rng_ok;
  logic [TW-1:0] run_q, eff_tmo;

  assign launch  = ctl_we && go_bit && (rd_bit != wr_bit) && (st != ST_BUSY);
  assign rng_ok  = (x_addr >= ADDR_BASE) && (x_addr <= ADDR_LIMIT);
  assign eff_tmo = (tmo_q == '0) ? TW'(1) : tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (x_req) run_q <= run_q + TW'(1);
    else            run_q <= '0;
  end

  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    st != ixb_st_e'(2'd3));

  a_r5_launch_req: assert property (@(posedge clk) disable iff (!rst_n)
    launch && rng_ok |=> x_req && (st == ST_BUSY));

  a_r6_oor_refused: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !rng_ok |=> !x_req && (st == ST_ERR));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    x_req && $past(x_req) |-> $stable(x_addr) && $stable(x_wdata) && $stable(x_we) && $stable(x_strb));

  a_r5_read_no_strb: assert property (@(posedge clk) disable iff (!rst_n)
    x_req && !x_we |-> x_strb == 4'h0);

  a_r7_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    x_req && x_ack |=> !x_req && (st == ST_IDLE));

  a_r8_req_window: assert property (@(posedge clk) disable iff (!rst_n)
    x_req |-> run_q < eff_tmo);

  a_r9_tmo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BUSY |=> $stable(tmo_q));
endmodule

bind ixb_bridge ixb_bridge_chk #(
  .AW(AW), .TW(TW), .ADDR_BASE(ADDR_BASE), .ADDR_LIMIT(ADDR_LIMIT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_s),
  .ctl_we  (ctl_we),
  .go_bit  (h_wdata[31]),
  .rd_bit  (h_wdata[0]),
  .wr_bit  (h_wdata[1]),
  .x_req   (x_req),
  .x_we    (x_we),
  .x_addr  (x_addr),
  .x_wdata (x_wdata),
  .x_strb  (x_strb),
  .x_ack   (x_ack),
  .st      (st),
  .tmo_q   (tmo_q)
);

// File: tb/test_ixb_bridge.sv
module test_ixb_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 1'b0, h_wr = 1'b0;
  logic [1:0]  h_idx = 2'd0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        x_req, x_we;
  logic [31:0] x_addr, x_wdata;
  logic [3:0]  x_strb;
  logic        x_ack = 1'b0;
  logic [31:0] x_rdata = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  ixb_bridge i_ixb_bridge (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_idx(h_idx),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .x_req(x_req), .x_we(x_we),
    .x_addr(x_addr), .x_wdata(x_wdata), .x_strb(x_strb), .x_ack(x_ack),
    .x_rdata(x_rdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    h_sel = 1'b1; h_wr = 1'b1; h_idx = idx; h_wdata = d;
    @(negedge clk);
    h_sel = 1'b0; h_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    h_sel = 1'b1; h_wr = 1'b0; h_idx = idx;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    h_sel = 1'b0;
  endtask

  task automatic ext_ack(input logic [31:0] d);
    @(negedge clk);
    x_ack = 1'b1; x_rdata = d;
    @(negedge clk);
    x_ack = 1'b0;
  endtask

  // monitor: compares host reads against the queued expectations
  always @(negedge clk) begin
    #5;
    if (h_sel && !h_wr && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(h_rdata, e, t);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk({31'd0, x_req}, 32'd0, "R1 x_req after reset");
    host_rd(2'd0, 32'h0, "R1 control reset");
    host_rd(2'd1, 32'h0, "R1 address reset");
    host_rd(2'd2, 32'h0, "R1 data reset");
    host_rd(2'd3, 32'h0000_0FFF, "R1 timeout reset");

    // R2 readback
    host_wr(2'd1, 32'h0000_1234);
    host_wr(2'd2, 32'hDEAD_BEEF);
    host_wr(2'd3, 32'h0000_0040);
    host_rd(2'd1, 32'h0000_1234, "R2 address readback");
    host_rd(2'd2, 32'hDEAD_BEEF, "R2 data readback");
    host_rd(2'd3, 32'h0000_0040, "R2 timeout readback");

    // R5/R7 write transfer, mask 0xC
    host_wr(2'd0, 32'h8000_00C2);
    chk({31'd0, x_req}, 32'd1, "R5 write x_req");
    chk({31'd0, x_we}, 32'd1, "R5 write x_we");
    chk(x_addr, 32'h0000_1234, "R5 write x_addr");
    chk(x_wdata, 32'hDEAD_BEEF, "R5 write x_wdata");
    chk({28'd0, x_strb}, 32'hC, "R5 write x_strb");
    host_rd(2'd0, 32'h0000_10C0, "R4 busy status with mask");
    ext_ack(32'h0000_0055);
    chk({31'd0, x_req}, 32'd0, "R7 x_req drops after ack");
    host_rd(2'd0, 32'h0000_00C0, "R7 idle after write");
    host_rd(2'd2, 32'hDEAD_BEEF, "R7 write keeps data");

    // R5/R7/R9 read transfer with ignored writes while busy
    host_wr(2'd1, 32'h0000_2000);
    host_wr(2'd0, 32'h8000_0031);
    chk({31'd0, x_we}, 32'd0, "R5 read x_we");
    chk({28'd0, x_strb}, 32'h0, "R5 read x_strb zero");
    host_wr(2'd1, 32'h0000_3000);
    host_wr(2'd2, 32'h0000_0001);
    host_wr(2'd3, 32'h0000_0005);
    host_wr(2'd0, 32'h8000_00F2);
    chk(x_addr, 32'h0000_2000, "R9 x_addr unchanged while busy");
    chk({31'd0, x_we}, 32'd0, "R9 direction unchanged while busy");
    host_rd(2'd0, 32'h0000_1030, "R9 control unchanged while busy");
    ext_ack(32'hCAFE_F00D);
    host_rd(2'd2, 32'hCAFE_F00D, "R7 read data loaded");
    host_rd(2'd1, 32'h0000_2000, "R9 address write ignored");
    host_rd(2'd3, 32'h0000_0040, "R9 timeout write ignored");
    host_rd(2'd0, 32'h0000_0030, "R7 idle after read");

    // R3 malformed control writes
    host_wr(2'd0, 32'h8000_00F3);
    chk({31'd0, x_req}, 32'd0, "R3 both directions");
    host_wr(2'd0, 32'h8000_00F0);
    chk({31'd0, x_req}, 32'd0, "R3 no direction");
    host_wr(2'd0, 32'h0000_00F2);
    chk({31'd0, x_req}, 32'd0, "R3 go clear");
    host_rd(2'd0, 32'h0000_0030, "R3 status and mask unchanged");

    // R6 below base
    host_wr(2'd1, 32'h0000_0FFF);
    host_wr(2'd0, 32'h8000_0011);
    chk({31'd0, x_req}, 32'd0, "R6 below base no request");
    host_rd(2'd0, 32'h0000_2010, "R6 error status");
    // R10 sticky error, then cleared by a valid launch at the limit
    host_wr(2'd0, 32'h8000_0003);
    host_rd(2'd0, 32'h0000_2010, "R10 error sticky on bad write");
    host_wr(2'd1, 32'h0000_FFFF);
    host_wr(2'd0, 32'h8000_0011);
    chk({31'd0, x_req}, 32'd1, "R10 launch from error at limit");
    host_rd(2'd0, 32'h0000_1010, "R10 busy after error");
    ext_ack(32'h0000_0777);
    host_wr(2'd1, 32'h0001_0000);
    host_wr(2'd0, 32'h8000_0011);
    chk({31'd0, x_req}, 32'd0, "R6 above limit no request");
    host_rd(2'd0, 32'h0000_2010, "R6 error above limit");

    // R8 timeout of 3 cycles without acknowledge
    host_wr(2'd1, 32'h0000_1000);
    host_wr(2'd2, 32'h0000_0077);
    host_wr(2'd3, 32'h0000_0003);
    host_wr(2'd0, 32'h8000_0001);
    chk({31'd0, x_req}, 32'd1, "R8 req cycle 1");
    @(negedge clk);
    chk({31'd0, x_req}, 32'd1, "R8 req cycle 2");
    @(negedge clk);
    chk({31'd0, x_req}, 32'd1, "R8 req cycle 3");
    @(negedge clk);
    chk({31'd0, x_req}, 32'd0, "R8 req dropped after timeout");
    host_rd(2'd0, 32'h0000_2000, "R8 timeout error status");
    host_rd(2'd2, 32'h0000_0077, "R8 data unchanged on timeout");

    // R8 acknowledge in the last allowed cycle
    host_wr(2'd3, 32'h0000_0002);
    host_wr(2'd0, 32'h8000_0001);
    ext_ack(32'h0000_ABCD);
    chk({31'd0, x_req}, 32'd0, "R8 req dropped after late ack");
    host_rd(2'd0, 32'h0000_0000, "R8 ack on last cycle is success");
    host_rd(2'd2, 32'h0000_ABCD, "R8 late ack data loaded");

    // R8 zero timeout acts as one
    host_wr(2'd3, 32'h0000_0000);
    host_wr(2'd0, 32'h8000_0001);
    chk({31'd0, x_req}, 32'd1, "R8 zero timeout cycle 1");
    @(negedge clk);
    chk({31'd0, x_req}, 32'd0, "R8 zero timeout dropped");
    host_rd(2'd0, 32'h0000_2000, "R8 zero timeout error");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule